// File: doc/BRIEF.md
# Compressed audio bitstream sync detector

This block watches the payload of a digital audio receiver, one 16-bit word per valid strobe, plus a separate pulse that marks each frame boundary. It looks for two kinds of compressed-stream signature. The first is the burst preamble that introduces a non-PCM data burst: four zero words, then 0xF872, then 0x4E1F. The second is the sync word of a DTS-CD stream, packed either in 16-bit form or in 14-bit form.

Either signature raises a sticky flag. A flag stays high until a fixed number of frames (4096 by default) has passed with no fresh signature. The two flags are ORed into a single auto flag, which downstream logic uses to mute or reroute the PCM path. The two words that follow a burst preamble carry the burst information and the length code. The block latches them so that a decoder can find out what kind of burst is coming and how long it is.

The asynchronous active-low reset is released through a synchronizer. A separate synchronous clear returns the detector to its idle state.

Top module: `audio_sync_detect`

## Requirements
- R1: A run of valid words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F raises npcm_flag on the clock edge that accepts the 0x4E1F word. Without such a run, npcm_flag never rises.
- R2: The non-PCM matcher tolerates long zero padding. A run of more than four zero words followed by 0xF872, 0x4E1F still matches. When a partial match breaks, the word that broke it is re-evaluated as a possible start of a new match; for example, a zero word in place of 0x4E1F counts as the first zero word of a new match.
- R3: Once set, npcm_flag stays at 1 until TIMEOUT frame pulses have arrived with no new preamble, and clears on the edge of the TIMEOUT-th pulse. Every new preamble restarts the frame count at zero.
- R4: The first valid word after a matched preamble is latched into burst_info, and the second into burst_len. Neither register changes at any other time.
- R5: With dts16_en high, the valid word pair 0x7FFE then 0x8001 raises dts_flag on the edge that accepts 0x8001. A repeated 0x7FFE keeps the partial match.
- R6: With dts14_en high, the valid words 0x1FFF, 0xE800, then a word whose bits [15:4] equal 0x07F raise dts_flag. A repeated 0x1FFF restarts the partial match at its first word.
- R7: A DTS format whose enable input is low never raises dts_flag.
- R8: dts_flag follows the same TIMEOUT-frame rule as R3, restarted by every detected DTS sync word.
- R9: auto_flag equals npcm_flag OR dts_flag in every cycle.
- R10: srst high on a clock edge clears both flags, both frame counters, both matchers, burst_info and burst_len. rst_n low does the same asynchronously.
- R11: Cycles with word_valid low neither advance nor break a partial match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| srst | input | 1 | Synchronous clear of all detector state |
| word_valid | input | 1 | word_data carries a new audio word |
| word_data | input | 16 | Audio payload word |
| frame_pulse | input | 1 | One-cycle pulse per frame boundary |
| dts14_en | input | 1 | Enables detection of the 14-bit DTS sync |
| dts16_en | input | 1 | Enables detection of the 16-bit DTS sync |
| npcm_flag | output | 1 | Non-PCM burst stream present |
| dts_flag | output | 1 | DTS-CD stream present |
| auto_flag | output | 1 | OR of the two flags |
| burst_info | output | 16 | Burst-information word captured after the preamble |
| burst_len | output | 16 | Length-code word captured after the preamble |

## Verification
On every cycle, the assertions check the following:
- a detected sync raises its flag on the next edge;
- a flag never rises without a detection;
- a flag can only fall on a frame pulse;
- a frame count is zero whenever its flag is low;
- a disabled DTS format yields no detection;
- the burst registers stay still on idle cycles;
- the synchronous clear empties the state.

Only the bench scenarios show the following:
- the exact content of the match, including long zero padding, broken partial matches and gaps in the valid strobe;
- the precise frame on which each flag times out, and the restart of that count by a new sync;
- which words land in the burst registers;
- the full sweep of the DTS enable and format combinations.

// File: rtl/asd_pkg.sv
package asd_pkg;
  localparam int unsigned WORD_W = 16;

  localparam logic [WORD_W-1:0] PRE_A     = 16'hF872;
  localparam logic [WORD_W-1:0] PRE_B     = 16'h4E1F;
  localparam logic [WORD_W-1:0] D16_FIRST = 16'h7FFE;
  localparam logic [WORD_W-1:0] D16_LAST  = 16'h8001;
  localparam logic [WORD_W-1:0] D14_FIRST = 16'h1FFF;
  localparam logic [WORD_W-1:0] D14_MID   = 16'hE800;
  localparam logic [11:0]       D14_TOP   = 12'h07F;

  typedef enum logic [2:0] {
    NP_IDLE, NP_Z1, NP_Z2, NP_Z3, NP_Z4, NP_PA, NP_PC, NP_PD
  } np_state_e;

  typedef enum logic [0:0] {D16_IDLE, D16_W1} d16_state_e;
  typedef enum logic [1:0] {D14_IDLE, D14_W1, D14_W2} d14_state_e;
endpackage

// File: rtl/asd_rst_sync.sv
module asd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      out_q  <= meta_q;
    end
  end

  assign rst_n_s = out_q;
endmodule

// File: rtl/asd_npcm_match.sv
module asd_npcm_match
  import asd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              vld,
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] pd
);
  np_state_e         st_q, st_d;
  logic [WORD_W-1:0] pc_q, pc_d, pd_q, pd_d;
  logic              is_zero;

  assign is_zero = (word == '0);

  always_comb begin
    st_d = st_q;
    pc_d = pc_q;
    pd_d = pd_q;
    hit  = 1'b0;
    unique case (st_q)
      NP_IDLE: st_d = is_zero ? NP_Z1 : NP_IDLE;
      NP_Z1:   st_d = is_zero ? NP_Z2 : NP_IDLE;
      NP_Z2:   st_d = is_zero ? NP_Z3 : NP_IDLE;
      NP_Z3:   st_d = is_zero ? NP_Z4 : NP_IDLE;
      NP_Z4: begin
        if (word == PRE_A)  st_d = NP_PA;
        else if (is_zero)   st_d = NP_Z4;
        else                st_d = NP_IDLE;
      end
      NP_PA: begin
        if (word == PRE_B) begin
          hit  = vld && !srst;
          st_d = NP_PC;
        end else if (is_zero) begin
          st_d = NP_Z1;
        end else begin
          st_d = NP_IDLE;
        end
      end
      NP_PC: begin
        pc_d = word;
        st_d = NP_PD;
      end
      NP_PD: begin
        pd_d = word;
        st_d = NP_IDLE;
      end
      default: st_d = NP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= NP_IDLE;
      pc_q <= '0;
      pd_q <= '0;
    end else if (srst) begin
      st_q <= NP_IDLE;
      pc_q <= '0;
      pd_q <= '0;
    end else if (vld) begin
      st_q <= st_d;
      pc_q <= pc_d;
      pd_q <= pd_d;
    end
  end

  assign pc = pc_q;
  assign pd = pd_q;
endmodule

// File: rtl/asd_dts_match.sv
module asd_dts_match
  import asd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              vld,
  input  logic [WORD_W-1:0] word,
  input  logic              en14,
  input  logic              en16,
  output logic              hit
);
  d16_state_e s16_q, s16_d;
  d14_state_e s14_q, s14_d;
  logic       hit16, hit14;
  logic       upd16, upd14;

  always_comb begin
    s16_d = s16_q;
    hit16 = 1'b0;
    unique case (s16_q)
      D16_IDLE: s16_d = (word == D16_FIRST) ? D16_W1 : D16_IDLE;
      D16_W1: begin
        if (word == D16_LAST) begin
          hit16 = 1'b1;
          s16_d = D16_IDLE;
        end else if (word == D16_FIRST) begin
          s16_d = D16_W1;
        end else begin
          s16_d = D16_IDLE;
        end
      end
      default: s16_d = D16_IDLE;
    endcase
    if (!en16) s16_d = D16_IDLE;
  end

  always_comb begin
    s14_d = s14_q;
    hit14 = 1'b0;
    unique case (s14_q)
      D14_IDLE: s14_d = (word == D14_FIRST) ? D14_W1 : D14_IDLE;
      D14_W1: begin
        if (word == D14_MID)        s14_d = D14_W2;
        else if (word == D14_FIRST) s14_d = D14_W1;
        else                        s14_d = D14_IDLE;
      end
      D14_W2: begin
        if (word[WORD_W-1:4] == D14_TOP) begin
          hit14 = 1'b1;
          s14_d = D14_IDLE;
        end else if (word == D14_FIRST) begin
          s14_d = D14_W1;
        end else begin
          s14_d = D14_IDLE;
        end
      end
      default: s14_d = D14_IDLE;
    endcase
    if (!en14) s14_d = D14_IDLE;
  end

  assign upd16 = vld || !en16;
  assign upd14 = vld || !en14;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      s16_q <= D16_IDLE;
    else if (srst)   s16_q <= D16_IDLE;
    else if (upd16)  s16_q <= s16_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      s14_q <= D14_IDLE;
    else if (srst)   s14_q <= D14_IDLE;
    else if (upd14)  s14_q <= s14_d;
  end

  assign hit = vld && !srst && ((hit16 && en16) || (hit14 && en14));
endmodule

// File: rtl/asd_frame_timer.sv
module asd_frame_timer #(
  parameter int unsigned TIMEOUT = 4096,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             hit,
  input  logic             frame,
  output logic             flag,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    if (hit) begin
      flag_d = 1'b1;
      cnt_d  = '0;
    end else if (flag_q) begin
      if (cnt_q == LAST) begin
        flag_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign upd = hit || frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (srst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign flag = flag_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/audio_sync_detect.sv
module audio_sync_detect
  import asd_pkg::*;
#(
  parameter int unsigned TIMEOUT = 4096,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              frame_pulse,
  input  logic              dts14_en,
  input  logic              dts16_en,
  output logic              npcm_flag,
  output logic              dts_flag,
  output logic              auto_flag,
  output logic [WORD_W-1:0] burst_info,
  output logic [WORD_W-1:0] burst_len
);
  localparam int unsigned NCH = 2;

  logic             rst_n_s;
  logic             npcm_hit, dts_hit;
  logic [NCH-1:0]   ch_hit, ch_flag;
  logic [CNT_W-1:0] ch_cnt [NCH];

  asd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  asd_npcm_match u_npcm (
    .clk   (clk),
    .rst_n (rst_n_s),
    .srst  (srst),
    .vld   (word_valid),
    .word  (word_data),
    .hit   (npcm_hit),
    .pc    (burst_info),
    .pd    (burst_len)
  );

  asd_dts_match u_dts (
    .clk   (clk),
    .rst_n (rst_n_s),
    .srst  (srst),
    .vld   (word_valid),
    .word  (word_data),
    .en14  (dts14_en),
    .en16  (dts16_en),
    .hit   (dts_hit)
  );

  assign ch_hit = {dts_hit, npcm_hit};

  for (genvar g = 0; g < NCH; g++) begin : g_tmr
    asd_frame_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n_s),
      .srst  (srst),
      .hit   (ch_hit[g]),
      .frame (frame_pulse),
      .flag  (ch_flag[g]),
      .cnt   (ch_cnt[g])
    );
  end

  assign npcm_flag = ch_flag[0];
  assign dts_flag  = ch_flag[1];
  assign auto_flag = |ch_flag;
endmodule

// File: rtl/asd_checker.sv
module asd_checker #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             srst,
  input logic             word_valid,
  input logic             frame_pulse,
  input logic             dts14_en,
  input logic             dts16_en,
  input logic             npcm_hit,
  input logic             dts_hit,
  input logic             npcm_flag,
  input logic             dts_flag,
  input logic [15:0]      burst_info,
  input logic [15:0]      burst_len,
  input logic [CNT_W-1:0] cnt_np,
  input logic [CNT_W-1:0] cnt_dts
);
  AST_NPCM_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    npcm_hit && !srst |=> npcm_flag); // R1
  AST_NPCM_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n_s)
    !npcm_flag && !npcm_hit |=> !npcm_flag); // R1
  AST_NPCM_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    npcm_flag && !frame_pulse && !srst |=> npcm_flag); // R3
  AST_NPCM_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !npcm_flag |-> cnt_np == '0); // R3
  AST_BURST_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !word_valid && !srst |=> $stable(burst_info) && $stable(burst_len)); // R4
  AST_DTS_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    dts_hit && !srst |=> dts_flag); // R5
  AST_DTS_OFF: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dts14_en && !dts16_en |-> !dts_hit); // R7
  AST_DTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    dts_flag && !frame_pulse && !srst |=> dts_flag); // R8
  AST_DTS_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dts_flag |-> cnt_dts == '0); // R8
  AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    srst |=> !npcm_flag && !dts_flag && burst_info == '0 && burst_len == '0); // R10
endmodule

bind audio_sync_detect asd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .srst        (srst),
  .word_valid  (word_valid),
  .frame_pulse (frame_pulse),
  .dts14_en    (dts14_en),
  .dts16_en    (dts16_en),
  .npcm_hit    (npcm_hit),
  .dts_hit     (dts_hit),
  .npcm_flag   (npcm_flag),
  .dts_flag    (dts_flag),
  .burst_info  (burst_info),
  .burst_len   (burst_len),
  .cnt_np      (ch_cnt[0]),
  .cnt_dts     (ch_cnt[1])
);

// File: tb/test_audio_sync_detect.sv
module test_audio_sync_detect;
  localparam int unsigned TO = 8;

  logic        clk = 1'b0;
  logic        rst_n, srst, word_valid, frame_pulse, dts14_en, dts16_en;
  logic [15:0] word_data;
  logic        npcm_flag, dts_flag, auto_flag;
  logic [15:0] burst_info, burst_len;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  audio_sync_detect #(.TIMEOUT(TO)) i_audio_sync_detect (
    .clk, .rst_n, .srst, .word_valid, .word_data, .frame_pulse,
    .dts14_en, .dts16_en, .npcm_flag, .dts_flag, .auto_flag,
    .burst_info, .burst_len
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    word_valid = 1'b1; word_data = w; frame_pulse = 1'b0; srst = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    word_valid = 1'b0; word_data = 16'hA5A5; frame_pulse = 1'b0; srst = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    word_valid = 1'b0; frame_pulse = 1'b1; srst = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    word_valid = 1'b0; frame_pulse = 1'b0; srst = 1'b1;
    idle();
  endtask

  task automatic preamble(input int zeros);
    for (int i = 0; i < zeros; i++) send(16'h0000);
    send(16'hF872);
    send(16'h4E1F);
  endtask

  task automatic timeout_sweep(input string req, input bit is_np);
    for (int i = 1; i <= int'(TO); i++) begin
      pulse();
      idle();
      chk(req, is_np ? npcm_flag : dts_flag, (i < int'(TO)) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; srst = 1'b0; word_valid = 1'b0; frame_pulse = 1'b0;
    word_data = '0; dts14_en = 1'b0; dts16_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
    chk("R10 reset npcm", npcm_flag, 0);
    chk("R10 reset dts", dts_flag, 0);
    chk("R10 reset burst", {burst_info, burst_len}, 0);

    // R1 / R4: basic preamble and capture
    preamble(4);
    idle();
    chk("R1 npcm set", npcm_flag, 1);
    chk("R9 auto npcm", auto_flag, 1);
    send(16'h0015); send(16'h1800); idle();
    chk("R4 pc", burst_info, 16'h0015);
    chk("R4 pd", burst_len, 16'h1800);
    send(16'h1234); send(16'h0000); send(16'h4E1F); idle();
    chk("R4 pc unchanged", burst_info, 16'h0015);
    chk("R4 pd unchanged", burst_len, 16'h1800);

    // R3: restart part-way then exact timeout
    for (int i = 0; i < 3; i++) begin pulse(); idle(); end
    preamble(4); send(16'h0001); send(16'h0002); idle();
    timeout_sweep("R3 npcm timeout", 1'b1);
    chk("R9 auto clear", auto_flag, 0);

    // R2: broken matches
    send(16'h0000); send(16'h0000); send(16'h0000); send(16'h0000);
    send(16'hF872); send(16'h1234); idle();
    chk("R2 broken no set", npcm_flag, 0);
    send(16'h0000); send(16'h0000); send(16'h0003); send(16'hF872); send(16'h4E1F); idle();
    chk("R2 short zeros no set", npcm_flag, 0);
    send(16'h0000); send(16'h0000); send(16'h0000); send(16'h0000);
    send(16'hF872); send(16'h0000);
    send(16'h0000); send(16'h0000); send(16'h0000);
    send(16'hF872); send(16'h4E1F); idle();
    chk("R2 reevaluated zero", npcm_flag, 1);
    send(16'h0000); send(16'h0000); idle();
    clear();
    for (int z = 4; z <= 9; z++) begin
      clear();
      preamble(z); idle();
      chk("R2 long zero run", npcm_flag, 1);
    end

    // R11: gaps in valid do not break a match
    clear();
    send(16'h0000); idle(); send(16'h0000); send(16'h0000); idle(); idle();
    send(16'h0000); idle(); send(16'hF872); idle(); send(16'h4E1F); idle();
    chk("R11 gaps npcm", npcm_flag, 1);
    send(16'hBEEF); idle(); send(16'hCAFE); idle();
    chk("R11 gaps pc", burst_info, 16'hBEEF);
    chk("R11 gaps pd", burst_len, 16'hCAFE);

    // R10: srst clears all
    clear();
    chk("R10 srst npcm", npcm_flag, 0);
    chk("R10 srst burst", {burst_info, burst_len}, 0);

    // R5 R6 R7: enable and format sweep
    for (int c = 0; c < 8; c++) begin
      bit e14 = c[0], e16 = c[1], fmt14 = c[2];
      clear();
      @(negedge clk); dts14_en = e14; dts16_en = e16;
      if (fmt14) begin
        send(16'h1FFF); send(16'hE800); send(16'h07F0 | 16'(c));
      end else begin
        send(16'h7FFE); send(16'h8001);
      end
      idle();
      chk(fmt14 ? "R6 R7 dts14 sweep" : "R5 R7 dts16 sweep", dts_flag,
          fmt14 ? e14 : e16);
      chk("R9 auto dts", auto_flag, fmt14 ? e14 : e16);
      chk("R1 npcm untouched", npcm_flag, 0);
    end

    @(negedge clk); dts14_en = 1'b1; dts16_en = 1'b1;
    clear();
    send(16'h1FFF); send(16'hE800); send(16'h0800); idle();
    chk("R6 bad third word", dts_flag, 0);
    send(16'h1FFF); send(16'h1FFF); send(16'hE800); idle(); send(16'h07F3); idle();
    chk("R6 R11 repeated first", dts_flag, 1);
    clear();
    send(16'h7FFE); send(16'h7FFE); send(16'h8001); idle();
    chk("R5 repeated first", dts_flag, 1);

    // R8: DTS timeout with restart
    for (int i = 0; i < 5; i++) begin pulse(); idle(); end
    send(16'h7FFE); send(16'h8001); idle();
    timeout_sweep("R8 dts timeout", 1'b0);

    // R9: both flags together
    preamble(4); send(16'h7FFE); send(16'h8001); idle();
    chk("R9 both", {npcm_flag, dts_flag, auto_flag}, 3'b111);
    clear();
    chk("R10 srst both", {npcm_flag, dts_flag, auto_flag}, 3'b000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule